// File: doc/BRIEF.md
# Temperature Alarm Event Generator

This block watches a stream of digital temperature samples and drives an active-low event line when the temperature leaves a programmed window or climbs past a critical ceiling. Software programs three signed limits, a release hysteresis, an operating mode and a master enable through a small write port. A one-cycle clear strobe acknowledges latched events. A three-bit status word shows which conditions are active.

Each sample is compared against the limits only when its valid strobe is high. Every condition trips on its limit and releases only once the temperature has moved back past the limit by the hysteresis margin. The mode sets how the window conditions drive the event line. In comparator mode the line follows the conditions. In interrupt mode it latches on each window crossing until software clears it. In critical-only mode it ignores the window. In every mode an active critical condition holds the event low, and the clear strobe cannot release it.

Top module: `tmp_alarm_evt`

## Requirements
- R1: After synchronous reset, `evt_n_o` is 1, `stat_o` is 0, all limits are 0, the mode is interrupt, the hysteresis code is 0 and the enable bit is 0.
- R2: A write with `wr_en_i` high stores `wr_data_i` into the register at `wr_addr_i`: 0 is the lower limit, 1 the upper limit, 2 the critical limit and 3 the control word. The control word holds mode in bits [1:0], hysteresis code in bits [3:2] and enable in bit 4. The new value applies from the next clock edge.
- R3: Conditions are updated only on a cycle with `temp_vld_i` high, and the result appears on `stat_o` one cycle later. Bit 0 (below) trips when temp < lower. Bit 1 (above) trips when temp > upper. Bit 2 (critical) trips when temp > critical. Without a valid sample, `stat_o` holds its value.
- R4: An active condition releases as follows. Below releases when temp >= lower + H. Above releases when temp <= upper - H. Critical releases when temp <= critical - H. H is 0, 6, 12 or 24 quarter-degree steps for hysteresis codes 0 to 3.
- R5: Comparator mode (mode 1) drives `evt_n_o` low exactly while any status bit is set. The clear strobe has no effect in this mode.
- R6: Interrupt mode (mode 0) works as follows. A sample that changes the below or above bit (trip or release) latches the event. `clr_i` drops the latch one cycle later. A crossing in the same cycle as a clear wins over the clear.
- R7: In critical-only mode (modes 2 and 3), only the critical bit drives the event. The below and above bits still show on `stat_o` but do not pull `evt_n_o` low.
- R8: With the enable bit set, an active critical bit holds `evt_n_o` low in every mode, and `clr_i` cannot release it.
- R9: With the enable bit clear, `evt_n_o` stays 1 and the interrupt latch is dropped.
- R10: Temperature and limits are 11-bit two's-complement values in quarter-degree steps, and all comparisons are signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| temp_vld_i | input | 1 | Temperature sample valid |
| temp_i | input | TW | Signed temperature, quarter-degree steps |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | TW | Register write data |
| clr_i | input | 1 | Software clear of the interrupt latch |
| evt_n_o | output | 1 | Event line, active low |
| stat_o | output | 3 | Active conditions: {critical, above, below} |

## Verification
The assertions check four mode rules on every cycle:
- In comparator mode the event line follows the status bits.
- In critical-only mode the event follows the critical bit alone.
- A critical condition always pulls the line low while enabled.
- A disabled block never signals.

They also check that the status holds between samples and that a clear without a crossing releases an interrupt-mode event. The bench's scenarios cover the rest:
- the exact hysteresis release points for each code;
- signed comparisons around negative limits;
- re-arming after a clear by a fresh crossing;
- the same-cycle race between a crossing and a clear;
- the behaviour of the line when modes change on top of live conditions.

// File: rtl/tmp_alarm_pkg.sv
package tmp_alarm_pkg;

    typedef enum logic [1:0] {
        MODE_INTR = 2'd0,
        MODE_COMP = 2'd1,
        MODE_CRIT = 2'd2,
        MODE_CRT2 = 2'd3
    } mode_e;

    typedef struct packed {
        logic       en;
        logic [1:0] hyst;
        mode_e      mode;
    } ctl_t;

    localparam int NCOND    = 3;
    localparam int C_BELOW  = 0;
    localparam int C_ABOVE  = 1;
    localparam int C_CRIT   = 2;
    localparam int HQ_W     = 5;

    // release margin in quarter-degree steps
    function automatic logic [HQ_W-1:0] hyst_steps(input logic [1:0] code);
        case (code)
            2'd0:    hyst_steps = 5'd0;
            2'd1:    hyst_steps = 5'd6;
            2'd2:    hyst_steps = 5'd12;
            default: hyst_steps = 5'd24;
        endcase
    endfunction

    function automatic logic is_crit_only(input mode_e m);
        is_crit_only = (m == MODE_CRIT) || (m == MODE_CRT2);
    endfunction

endpackage

// File: rtl/tmp_cfg_regs.sv
module tmp_cfg_regs
    import tmp_alarm_pkg::*;
#(
    parameter int TW = 11,
    parameter int AW = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [TW-1:0]        wr_data_i,
    output logic signed [TW-1:0] lim_lo_o,
    output logic signed [TW-1:0] lim_hi_o,
    output logic signed [TW-1:0] lim_cr_o,
    output ctl_t                 ctl_o
);
    localparam int A_LO  = 0;
    localparam int A_HI  = 1;
    localparam int A_CR  = 2;
    localparam int A_CTL = 3;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_lo_o <= '0;
            lim_hi_o <= '0;
            lim_cr_o <= '0;
            ctl_o    <= '{en: 1'b0, hyst: 2'd0, mode: MODE_INTR};
        end else if (wr_en_i) begin
            case (int'(wr_addr_i))
                A_LO:  lim_lo_o <= signed'(wr_data_i);
                A_HI:  lim_hi_o <= signed'(wr_data_i);
                A_CR:  lim_cr_o <= signed'(wr_data_i);
                A_CTL: begin
                    ctl_o.mode <= mode_e'(wr_data_i[1:0]);
                    ctl_o.hyst <= wr_data_i[3:2];
                    ctl_o.en   <= wr_data_i[4];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmp_thr_trk.sv
module tmp_thr_trk
    import tmp_alarm_pkg::*;
#(
    parameter int TW        = 11,
    parameter bit TRIP_HIGH = 1'b1
) (
    input  logic signed [TW-1:0] temp_i,
    input  logic signed [TW-1:0] lim_i,
    input  logic [HQ_W-1:0]      hq_i,
    input  logic                 act_i,
    output logic                 act_o
);
    localparam int EW = TW + 2;

    logic signed [EW-1:0] t_x, l_x, h_x;
    logic trip, rel;

    assign t_x = signed'({{2{temp_i[TW-1]}}, temp_i});
    assign l_x = signed'({{2{lim_i[TW-1]}}, lim_i});
    assign h_x = signed'({{(EW-HQ_W){1'b0}}, hq_i});

    generate
        if (TRIP_HIGH) begin : g_high
            always_comb begin
                trip = t_x > l_x;
                rel  = t_x <= (l_x - h_x);
            end
        end else begin : g_low
            always_comb begin
                trip = t_x < l_x;
                rel  = t_x >= (l_x + h_x);
            end
        end
    endgenerate

    assign act_o = act_i ? !rel : trip;
endmodule

// File: rtl/tmp_evt_ctrl.sv
module tmp_evt_ctrl
    import tmp_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic             clr_i,
    input  ctl_t             ctl_i,
    input  logic [NCOND-1:0] cause_nxt_i,
    output logic [NCOND-1:0] cause_q_o,
    output logic             evt_o
);
    logic int_q, int_d;
    logic win_chg;
    logic mode_sel;

    assign win_chg = vld_i &&
        ((cause_nxt_i[C_ABOVE] != cause_q_o[C_ABOVE]) ||
         (cause_nxt_i[C_BELOW] != cause_q_o[C_BELOW]));

    always_comb begin
        if (!ctl_i.en || ctl_i.mode != MODE_INTR) int_d = 1'b0;
        else if (win_chg)                         int_d = 1'b1;
        else if (clr_i)                           int_d = 1'b0;
        else                                      int_d = int_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q_o <= '0;
            int_q     <= 1'b0;
        end else begin
            if (vld_i) cause_q_o <= cause_nxt_i;
            int_q <= int_d;
        end
    end

    always_comb begin
        case (ctl_i.mode)
            MODE_INTR: mode_sel = int_q;
            MODE_COMP: mode_sel = cause_q_o[C_ABOVE] | cause_q_o[C_BELOW];
            default:   mode_sel = 1'b0;
        endcase
    end

    assign evt_o = ctl_i.en & (cause_q_o[C_CRIT] | mode_sel);
endmodule

// File: rtl/tmp_alarm_evt.sv
module tmp_alarm_evt
    import tmp_alarm_pkg::*;
#(
    parameter int TW = 11,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          temp_vld_i,
    input  logic [TW-1:0] temp_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [TW-1:0] wr_data_i,
    input  logic          clr_i,
    output logic          evt_n_o,
    output logic [2:0]    stat_o
);
    logic signed [TW-1:0] lim_lo, lim_hi, lim_cr;
    logic signed [TW-1:0] lim_a [NCOND];
    ctl_t                 cfg;
    logic [HQ_W-1:0]      hq;
    logic [NCOND-1:0]     cause_q, cause_nxt;
    logic                 evt;

    tmp_cfg_regs #(.TW(TW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .lim_lo_o (lim_lo),
        .lim_hi_o (lim_hi),
        .lim_cr_o (lim_cr),
        .ctl_o    (cfg)
    );

    assign lim_a[C_BELOW] = lim_lo;
    assign lim_a[C_ABOVE] = lim_hi;
    assign lim_a[C_CRIT]  = lim_cr;
    assign hq = hyst_steps(cfg.hyst);

    for (genvar g = 0; g < NCOND; g++) begin : g_trk
        tmp_thr_trk #(.TW(TW), .TRIP_HIGH(g != C_BELOW)) u_trk (
            .temp_i(signed'(temp_i)),
            .lim_i (lim_a[g]),
            .hq_i  (hq),
            .act_i (cause_q[g]),
            .act_o (cause_nxt[g])
        );
    end

    tmp_evt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .vld_i      (temp_vld_i),
        .clr_i      (clr_i),
        .ctl_i      (cfg),
        .cause_nxt_i(cause_nxt),
        .cause_q_o  (cause_q),
        .evt_o      (evt)
    );

    assign evt_n_o = ~evt;
    assign stat_o  = cause_q;
endmodule

// File: rtl/tmp_alarm_chk.sv
module tmp_alarm_chk
    import tmp_alarm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       vld,
    input logic       clr,
    input logic       wr_en,
    input ctl_t       ctl,
    input logic       evt_n,
    input logic [2:0] stat
);
    // R8
    a_r8_crit_forces: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && stat[C_CRIT]) |-> !evt_n);

    // R5
    a_r5_comp_follows: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.mode == MODE_COMP) |-> (evt_n == !(|stat)));

    // R7
    a_r7_crit_only: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && is_crit_only(ctl.mode)) |-> (evt_n == !stat[C_CRIT]));

    // R9
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |-> evt_n);

    // R3
    a_r3_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(stat));

    // R6
    a_r6_clear_releases: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.mode == MODE_INTR && clr && !vld && !wr_en && !stat[C_CRIT])
        |=> evt_n);
endmodule

bind tmp_alarm_evt tmp_alarm_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .vld  (temp_vld_i),
    .clr  (clr_i),
    .wr_en(wr_en_i),
    .ctl  (cfg),
    .evt_n(evt_n_o),
    .stat (stat_o)
);

// File: tb/tmp_alarm_evt_bench.sv
module tmp_alarm_evt_bench;
    localparam int TW = 11;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          temp_vld_i = 1'b0;
    logic [TW-1:0] temp_i = '0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [TW-1:0] wr_data_i = '0;
    logic          clr_i = 1'b0;
    logic          evt_n_o;
    logic [2:0]    stat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_lo, m_hi, m_cr, m_mode, m_hy, m_en;
    bit m_b, m_a, m_c, m_int;

    always #4 clk = ~clk;

    tmp_alarm_evt #(.TW(TW), .AW(AW)) u_tmp_alarm_evt (.*);

    function automatic int sx(input logic [TW-1:0] v);
        return int'(signed'(v));
    endfunction

    function automatic int hyst_of(input int code);
        case (code)
            0: return 0;
            1: return 6;
            2: return 12;
            default: return 24;
        endcase
    endfunction

    function automatic bit exp_evt();
        bit s;
        if (m_mode == 0)      s = m_int;
        else if (m_mode == 1) s = m_a | m_b;
        else                  s = 1'b0;
        return (m_en != 0) && (m_c || s);
    endfunction

    task automatic model();
        int t, h;
        bit nb, na, nc, chg;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_cr = 0; m_mode = 0; m_hy = 0; m_en = 0;
            m_b = 0; m_a = 0; m_c = 0; m_int = 0;
            return;
        end
        t = sx(temp_i);
        h = hyst_of(m_hy);
        nb = m_b ? !(t >= m_lo + h) : (t < m_lo);
        na = m_a ? !(t <= m_hi - h) : (t > m_hi);
        nc = m_c ? !(t <= m_cr - h) : (t > m_cr);
        chg = temp_vld_i && ((nb != m_b) || (na != m_a));
        if (m_en == 0 || m_mode != 0) m_int = 0;
        else if (chg)                 m_int = 1;
        else if (clr_i)               m_int = 0;
        if (temp_vld_i) begin m_b = nb; m_a = na; m_c = nc; end
        if (wr_en_i) begin
            case (int'(wr_addr_i))
                0: m_lo = sx(wr_data_i);
                1: m_hi = sx(wr_data_i);
                2: m_cr = sx(wr_data_i);
                default: begin
                    m_mode = int'(wr_data_i[1:0]);
                    m_hy   = int'(wr_data_i[3:2]);
                    m_en   = int'(wr_data_i[4]);
                end
            endcase
        end
    endtask

    task automatic tick(input string tag);
        logic [2:0] es;
        bit ee;
        @(posedge clk);
        #1;
        model();
        es = {m_c, m_a, m_b};
        ee = exp_evt();
        n_chk++;
        if (evt_n_o !== !ee || stat_o !== es) begin
            n_bad++;
            $display("FAIL %s evt_n=%0b exp %0b stat=%03b exp %03b",
                     tag, evt_n_o, !ee, stat_o, es);
        end
    endtask

    task automatic samp(input int t, input string tag);
        temp_vld_i = 1'b1; temp_i = t[TW-1:0];
        tick(tag);
        temp_vld_i = 1'b0;
    endtask

    task automatic wr(input int a, input int d, input string tag);
        wr_en_i = 1'b1; wr_addr_i = a[AW-1:0]; wr_data_i = d[TW-1:0];
        tick(tag);
        wr_en_i = 1'b0;
    endtask

    task automatic ctl(input int mode, input int hy, input int en, input string tag);
        wr(3, (en << 4) | (hy << 2) | mode, tag);
    endtask

    task automatic clr(input string tag);
        clr_i = 1'b1;
        tick(tag);
        clr_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        tick("R1"); tick("R1");
        rst = 1'b0;
        tick("R1");

        // R2/R3/R4/R5: comparator window with hysteresis code 1
        wr(0, -40, "R2"); wr(1, 100, "R2"); wr(2, 200, "R2");
        ctl(1, 1, 1, "R2");
        samp(50, "R3");
        samp(101, "R3");
        samp(100, "R4"); samp(95, "R4"); samp(94, "R4");
        samp(-41, "R10"); samp(-40, "R10");
        clr("R5");
        samp(-35, "R4"); samp(-34, "R4");
        tick("R3");

        // R8: critical forces event across modes and clears
        samp(201, "R8");
        ctl(0, 2, 1, "R8");
        clr("R8"); clr("R8");
        samp(189, "R4"); samp(188, "R8");
        clr("R6");

        // R7: critical-only ignores window
        ctl(2, 0, 1, "R7");
        samp(150, "R7"); samp(-100, "R7");
        ctl(3, 0, 1, "R7");
        samp(250, "R7"); samp(0, "R7");

        // R6: interrupt latch, clear, re-arm, race with clear
        ctl(0, 0, 1, "R6");
        samp(120, "R6"); tick("R6"); clr("R6"); tick("R6");
        samp(80, "R6"); clr("R6");
        clr_i = 1'b1; samp(130, "R6"); clr_i = 1'b0;
        tick("R6"); clr("R6");

        // R9: disabled
        samp(300, "R9");
        ctl(1, 0, 0, "R9");
        samp(-300, "R9"); tick("R9");
        ctl(1, 3, 1, "R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            string tag;
            r = int'($urandom_range(99));
            if (r < 4) begin
                int a;
                a = int'($urandom_range(3));
                case (a)
                    0: wr_data_i = 11'(int'($urandom_range(200)) - 200);
                    1: wr_data_i = 11'(int'($urandom_range(200)));
                    2: wr_data_i = 11'(int'($urandom_range(200)) + 100);
                    default: wr_data_i = 11'({($urandom_range(7) != 0), 4'($urandom_range(15))});
                endcase
                wr_en_i = 1'b1; wr_addr_i = a[AW-1:0];
            end
            temp_vld_i = ($urandom_range(1) == 1);
            temp_i = 11'(int'($urandom_range(800)) - 400);
            if ($urandom_range(2) == 0)
                temp_i = 11'(m_hi + int'($urandom_range(60)) - 30);
            clr_i = ($urandom_range(4) == 0);
            if (m_mode == 0)      tag = "R6";
            else if (m_mode == 1) tag = "R5";
            else                  tag = "R7";
            if (m_c) tag = "R8";
            if (m_en == 0) tag = "R9";
            tick(tag);
            wr_en_i = 1'b0; temp_vld_i = 1'b0; clr_i = 1'b0;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule